// File: doc/BRIEF.md
# Low-Resolution Constant Twiddle Rotator

This block rotates one complex two's complement sample by a twiddle factor W^k = exp(-j*2*pi*k/RES), where the resolution RES is 4, 8 or 16 and is fixed when the block is elaborated. It is meant to sit between butterfly stages of a pipelined FFT wherever the twiddle set is small enough that a general complex multiplier and a coefficient memory would be wasted.

The index is split in two parts. Its top two bits pick a quarter-turn, which is applied exactly by exchanging the real and imaginary parts and negating. Its remaining low bits pick a residual angle below a quarter-turn, applied by hard-wired constant products built only from shifts and adds. The constants are the cosine and sine of pi/8 and the cosine of pi/4, quantised to 12-bit two's complement with 11 fraction bits. The two products of each output part are summed, rounded to nearest, and saturated back to the sample width. Results appear two clock cycles after the input, with a valid flag carried alongside.

Top module: `lowres_twiddle_rot`

## Requirements
- R1: A sample accepted with in_valid high appears on the outputs with out_valid high exactly two rising clock edges later; out_valid is low in every other cycle.
- R2: in_idx is log2(RES) bits wide and holds k in 0..RES-1; the output is the input multiplied by exp(-j*2*pi*k/RES).
- R3: When k is a multiple of RES/4, the result is exact with no rounding: quarter-turn q = k/(RES/4) gives (re, im) for q=0, (im, -re) for q=1, (-re, -im) for q=2 and (-im, re) for q=3.
- R4: For other k, with residual angle phi = (k mod RES/4)*2*pi/RES, c = round(cos(phi)*2048) and s = round(sin(phi)*2048), the quarter-turned sample (a, b) gives real (a*c + b*s)/2048 and imaginary (b*c - a*s)/2048, rounded to nearest, within 1 LSB.
- R5: Any result outside the DATA_W two's complement range saturates to the nearest limit; negating the most negative value yields the most positive value.
- R6: The outputs hold their last value in every cycle where out_valid is low.
- R7: While rst_n is low, out_valid, out_re and out_im are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is present this cycle |
| in_re | input | DATA_W | Real part of the input, two's complement |
| in_im | input | DATA_W | Imaginary part of the input, two's complement |
| in_idx | input | IDX_W | Twiddle exponent k, IDX_W = log2(RES) |
| out_valid | output | 1 | Output sample is present this cycle |
| out_re | output | DATA_W | Real part of the rotated sample |
| out_im | output | DATA_W | Imaginary part of the rotated sample |

## Verification
The properties assume in_valid is held low through reset, so the two-cycle valid history they look back on starts out clean, and the bench drives it low until after release. They also assume the index is always in range, which the bench guarantees by drawing it modulo RES. Random samples span the full signed range, including the most negative value, so the saturating corner of the half-turn check is reached; directed cases sweep every index and push the pi/4 path into overflow.

// File: rtl/twr_pkg.sv
package twr_pkg;
   // Coefficient format: 12-bit two's complement, 11 fraction bits.
   localparam int COEF_W    = 12;
   localparam int COEF_FRAC = COEF_W - 1;
   // round(cos(pi/8)*2048), round(sin(pi/8)*2048), round(cos(pi/4)*2048)
   localparam int K_C22 = 1892;
   localparam int K_S22 = 784;
   localparam int K_C45 = 1448;
endpackage

// File: rtl/twr_quadrant.sv
module twr_quadrant #(
   parameter int DATA_W = 16
) (
   input  logic        [1:0]      quad,
   input  logic signed [DATA_W-1:0] x_re,
   input  logic signed [DATA_W-1:0] x_im,
   output logic signed [DATA_W:0]   y_re,
   output logic signed [DATA_W:0]   y_im
);
   logic signed [DATA_W:0] er, ei;
   assign er = {x_re[DATA_W-1], x_re};
   assign ei = {x_im[DATA_W-1], x_im};

   always_comb begin
      unique case (quad)
         2'd0:    begin y_re = er;  y_im = ei;  end
         2'd1:    begin y_re = ei;  y_im = -er; end
         2'd2:    begin y_re = -er; y_im = -ei; end
         default: begin y_re = -ei; y_im = er;  end
      endcase
   end
endmodule

// File: rtl/twr_const_mul.sv
module twr_const_mul #(
   parameter int IN_W = 17,
   parameter int KW   = 12,
   parameter int K    = 1448
) (
   input  logic signed [IN_W-1:0]    x,
   output logic signed [IN_W+KW-1:0] p
);
   localparam int PW = IN_W + KW;

   if (K < 0 || K >= (1 << (KW - 1))) begin : g_bad_k
      $error("twr_const_mul: constant out of range");
   end

   logic signed [PW-1:0] ext;
   assign ext = PW'(x);

   // Shift-add network: one shifted term per set bit of the constant.
   always_comb begin
      p = '0;
      for (int b = 0; b < KW - 1; b++) begin
         if (((K >> b) & 1) != 0) p = p + (ext <<< b);
      end
   end
endmodule

// File: rtl/twr_residual.sv
module twr_residual
   import twr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int RES    = 16,
   parameter int SUB_W  = 2
) (
   input  logic signed [DATA_W:0]   a_re,
   input  logic signed [DATA_W:0]   a_im,
   input  logic        [SUB_W-1:0]  sub,
   output logic signed [DATA_W-1:0] y_re,
   output logic signed [DATA_W-1:0] y_im
);
   localparam int IN_W = DATA_W + 1;
   localparam int PW   = IN_W + COEF_W;
   localparam int AW   = PW + 1;
   localparam logic signed [AW-1:0] HALF = AW'(1) <<< (COEF_FRAC - 1);
   localparam logic signed [AW-1:0] MAXV = AW'((1 << (DATA_W - 1)) - 1);
   localparam logic signed [AW-1:0] MINV = -(AW'(1) <<< (DATA_W - 1));

   logic signed [AW-1:0] acc_re, acc_im, unit_re, unit_im;
   assign unit_re = AW'(a_re) <<< COEF_FRAC;
   assign unit_im = AW'(a_im) <<< COEF_FRAC;

   if (RES == 4) begin : g_w4
      logic unused_sub;
      assign unused_sub = ^sub;
      assign acc_re = unit_re;
      assign acc_im = unit_im;
   end else if (RES == 8) begin : g_w8
      logic signed [PW-1:0] r45, i45;
      twr_const_mul #(.IN_W(IN_W), .KW(COEF_W), .K(K_C45)) u_r45 (.x(a_re), .p(r45));
      twr_const_mul #(.IN_W(IN_W), .KW(COEF_W), .K(K_C45)) u_i45 (.x(a_im), .p(i45));
      always_comb begin
         if (sub[0]) begin
            acc_re = AW'(r45) + AW'(i45);
            acc_im = AW'(i45) - AW'(r45);
         end else begin
            acc_re = unit_re;
            acc_im = unit_im;
         end
      end
   end else begin : g_w16
      logic signed [PW-1:0] rc, rs, r45, ic, is_, i45;
      twr_const_mul #(.IN_W(IN_W), .KW(COEF_W), .K(K_C22)) u_rc  (.x(a_re), .p(rc));
      twr_const_mul #(.IN_W(IN_W), .KW(COEF_W), .K(K_S22)) u_rs  (.x(a_re), .p(rs));
      twr_const_mul #(.IN_W(IN_W), .KW(COEF_W), .K(K_C45)) u_r45 (.x(a_re), .p(r45));
      twr_const_mul #(.IN_W(IN_W), .KW(COEF_W), .K(K_C22)) u_ic  (.x(a_im), .p(ic));
      twr_const_mul #(.IN_W(IN_W), .KW(COEF_W), .K(K_S22)) u_is  (.x(a_im), .p(is_));
      twr_const_mul #(.IN_W(IN_W), .KW(COEF_W), .K(K_C45)) u_i45 (.x(a_im), .p(i45));
      always_comb begin
         unique case (sub)
            2'd0: begin acc_re = unit_re;                 acc_im = unit_im;                 end
            2'd1: begin acc_re = AW'(rc)  + AW'(is_);    acc_im = AW'(ic)  - AW'(rs);      end
            2'd2: begin acc_re = AW'(r45) + AW'(i45);    acc_im = AW'(i45) - AW'(r45);     end
            default: begin acc_re = AW'(rs) + AW'(ic);   acc_im = AW'(is_) - AW'(rc);      end
         endcase
      end
   end

   logic signed [AW-1:0] rnd_re, rnd_im;
   assign rnd_re = (acc_re + HALF) >>> COEF_FRAC;
   assign rnd_im = (acc_im + HALF) >>> COEF_FRAC;

   always_comb begin
      if (rnd_re > MAXV)      y_re = MAXV[DATA_W-1:0];
      else if (rnd_re < MINV) y_re = MINV[DATA_W-1:0];
      else                    y_re = rnd_re[DATA_W-1:0];
      if (rnd_im > MAXV)      y_im = MAXV[DATA_W-1:0];
      else if (rnd_im < MINV) y_im = MINV[DATA_W-1:0];
      else                    y_im = rnd_im[DATA_W-1:0];
   end
endmodule

// File: rtl/lowres_twiddle_rot.sv
module lowres_twiddle_rot #(
   parameter int DATA_W = 16,
   parameter int RES    = 16,
   parameter int IDX_W  = $clog2(RES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_re,
   input  logic signed [DATA_W-1:0] in_im,
   input  logic        [IDX_W-1:0]  in_idx,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_re,
   output logic signed [DATA_W-1:0] out_im
);
   localparam int SUB_W = (IDX_W > 2) ? IDX_W - 2 : 1;

   if (!(RES == 4 || RES == 8 || RES == 16)) begin : g_bad_res
      $error("lowres_twiddle_rot: RES must be 4, 8 or 16");
   end
   if (IDX_W != $clog2(RES)) begin : g_bad_idx
      $error("lowres_twiddle_rot: IDX_W must equal log2(RES)");
   end
   if (DATA_W < 4) begin : g_bad_w
      $error("lowres_twiddle_rot: DATA_W too small");
   end

   logic [1:0]       quad_in;
   logic [SUB_W-1:0] sub_in;
   assign quad_in = in_idx[IDX_W-1:IDX_W-2];
   if (IDX_W > 2) begin : g_sub
      assign sub_in = in_idx[SUB_W-1:0];
   end else begin : g_nosub
      assign sub_in = '0;
   end

   logic signed [DATA_W:0] q_re, q_im;
   twr_quadrant #(.DATA_W(DATA_W)) u_quad (
      .quad(quad_in), .x_re(in_re), .x_im(in_im), .y_re(q_re), .y_im(q_im)
   );

   // Stage 1: quarter-turned sample, exact, one extra bit of headroom.
   logic                   s1_valid;
   logic signed [DATA_W:0] s1_re, s1_im;
   logic [SUB_W-1:0]       s1_sub;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_re    <= '0;
         s1_im    <= '0;
         s1_sub   <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_re  <= q_re;
            s1_im  <= q_im;
            s1_sub <= sub_in;
         end
      end
   end

   logic signed [DATA_W-1:0] r_re, r_im;
   twr_residual #(.DATA_W(DATA_W), .RES(RES), .SUB_W(SUB_W)) u_res (
      .a_re(s1_re), .a_im(s1_im), .sub(s1_sub), .y_re(r_re), .y_im(r_im)
   );

   // Stage 2: constant rotation, rounding, saturation.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_re    <= '0;
         out_im    <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) begin
            out_re <= r_re;
            out_im <= r_im;
         end
      end
   end
endmodule

// File: rtl/twr_checker.sv
module twr_checker #(
   parameter int DATA_W = 16,
   parameter int RES    = 16,
   parameter int IDX_W  = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic signed [DATA_W-1:0] in_re,
   input logic signed [DATA_W-1:0] in_im,
   input logic        [IDX_W-1:0]  in_idx,
   input logic                     out_valid,
   input logic signed [DATA_W-1:0] out_re,
   input logic signed [DATA_W-1:0] out_im
);
   localparam logic signed [DATA_W-1:0] MAXV = DATA_W'((1 << (DATA_W - 1)) - 1);
   localparam logic signed [DATA_W-1:0] MINV = ~MAXV;
   localparam logic [IDX_W-1:0] HALF_IDX = IDX_W'(RES / 2);

   assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid, 2));

   assert_zero_index_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid, 2) && $past(in_idx, 2) == '0) |->
      (out_re == $past(in_re, 2) && out_im == $past(in_im, 2)));

   assert_half_turn_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid, 2) && $past(in_idx, 2) == HALF_IDX && $past(in_re, 2) == MINV) |->
      (out_re == MAXV));

   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid, 2) |-> ($stable(out_re) && $stable(out_im)));
endmodule

bind lowres_twiddle_rot twr_checker #(.DATA_W(DATA_W), .RES(RES), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
   .in_idx(in_idx), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
);

// File: tb/tb_lowres_twiddle_rot.sv
module tb_lowres_twiddle_rot;
   localparam int DATA_W = 16;
   localparam int RES    = 16;
   localparam int IDX_W  = 4;
   localparam int MAXV   = (1 << (DATA_W - 1)) - 1;
   localparam int MINV   = -(1 << (DATA_W - 1));
   localparam real PI    = 3.14159265358979;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [DATA_W-1:0] in_re = '0, in_im = '0;
   logic [IDX_W-1:0] in_idx = '0;
   logic out_valid;
   logic signed [DATA_W-1:0] out_re, out_im;

   always #10 clk = ~clk;

   lowres_twiddle_rot #(.DATA_W(DATA_W), .RES(RES), .IDX_W(IDX_W)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
      .in_idx(in_idx), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
   );

   typedef struct { int re; int im; int due; int tag; } exp_t;
   exp_t fifo[$];
   int checks = 0, errors = 0, cyc = 0;
   int last_re = 0, last_im = 0;
   bit done = 0;

   function automatic int sat(int v);
      if (v > MAXV) return MAXV;
      if (v < MINV) return MINV;
      return v;
   endfunction

   function automatic string tname(int t);
      case (t)
         1: return "R1"; 2: return "R2"; 3: return "R3";
         4: return "R4"; 5: return "R5"; 6: return "R6";
         default: return "R7";
      endcase
   endfunction

   // Expected rotation built from the requirement text.
   task automatic model(input int xr, input int xi, input int k, input int force_tag,
                        output int er, output int ei, output int tag);
      int q, sb, a, b, c, s, ur, ui;
      real fr, fi, ph;
      q  = k / (RES / 4);
      sb = k % (RES / 4);
      case (q)
         0: begin a = xr;  b = xi;  end
         1: begin a = xi;  b = -xr; end
         2: begin a = -xr; b = -xi; end
         default: begin a = -xi; b = xr; end
      endcase
      ph = sb * 2.0 * PI / RES;
      c  = $rtoi($floor($cos(ph) * 2048.0 + 0.5));
      s  = $rtoi($floor($sin(ph) * 2048.0 + 0.5));
      fr = (a * c + b * s) / 2048.0;
      fi = (b * c - a * s) / 2048.0;
      ur = $rtoi($floor(fr + 0.5));
      ui = $rtoi($floor(fi + 0.5));
      er = sat(ur);
      ei = sat(ui);
      if (ur != er || ui != ei) tag = 5;
      else if (sb == 0)         tag = 3;
      else                      tag = 4;
      if (force_tag != 0) tag = force_tag;
   endtask

   task automatic check_out();
      bit ev;
      exp_t e;
      int dr, di;
      ev = (fifo.size() > 0) && (fifo[0].due == cyc);
      checks++;
      if (out_valid !== ev) begin
         errors++;
         $display("FAIL R1 cycle %0d out_valid act %0b exp %0b", cyc, out_valid, ev);
      end
      if (ev) begin
         e = fifo.pop_front();
         dr = int'(out_re) - e.re;
         di = int'(out_im) - e.im;
         checks++;
         if (dr > 1 || dr < -1 || di > 1 || di < -1) begin
            errors++;
            $display("FAIL %s cycle %0d act (%0d,%0d) exp (%0d,%0d)", tname(e.tag), cyc,
                     out_re, out_im, e.re, e.im);
         end
         last_re = int'(out_re);
         last_im = int'(out_im);
      end else begin
         checks++;
         if (int'(out_re) != last_re || int'(out_im) != last_im) begin
            errors++;
            $display("FAIL R6 cycle %0d act (%0d,%0d) exp (%0d,%0d)", cyc, out_re, out_im,
                     last_re, last_im);
         end
      end
   endtask

   task automatic step(input bit v, input int xr, input int xi, input int k, input int ft);
      exp_t e;
      @(negedge clk);
      check_out();
      in_valid = v;
      in_re    = DATA_W'(xr);
      in_im    = DATA_W'(xi);
      in_idx   = IDX_W'(k);
      if (v) begin
         model(xr, xi, k, ft, e.re, e.im, e.tag);
         e.due = cyc + 2;
         fifo.push_back(e);
      end
      cyc++;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R7: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_re !== '0 || out_im !== '0) begin
         errors++;
         $display("FAIL R7 act v=%0b (%0d,%0d) exp v=0 (0,0)", out_valid, out_re, out_im);
      end
      rst_n = 1'b1;
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);

      // R2: sweep every index with one sample
      for (int k = 0; k < RES; k++) step(1, 1000, 300, k, 2);
      // R3: exact quarter-turns with odd values
      step(1, 12345, -321, 0, 0);
      step(1, 12345, -321, 4, 0);
      step(1, 12345, -321, 8, 0);
      step(1, 12345, -321, 12, 0);
      // R4: constant paths
      step(1, -20000, 7777, 1, 0);
      step(1, 5, -3, 3, 0);
      step(1, 30000, 30000, 6, 0);
      // R5: saturation corners
      step(1, MINV, 0, 8, 0);
      step(1, 0, MINV, 4, 0);
      step(1, MAXV, MAXV, 2, 0);
      step(1, MINV, MINV, 2, 0);
      // R6: gap with hold
      step(0, 111, 222, 5, 0);
      step(0, 333, 444, 7, 0);
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      // Random stream, R1 valid gaps included
      for (int n = 0; n < 3000; n++) begin
         int xr, xi, k;
         bit v;
         xr = int'($signed(16'($urandom())));
         xi = int'($signed(16'($urandom())));
         k  = int'($urandom() % RES);
         v  = ($urandom() % 4) != 0;
         step(v, xr, xi, k, 0);
      end
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule